// File: doc/BRIEF.md
# Truth-Table Programmable Logic Unit

This block is a bitwise logic unit that can produce any of the sixteen Boolean functions of two operands. Software or a control path does not pick the function from an opcode that has to be decoded. It supplies a 4-bit function code, and that code is the truth table of the wanted function. Each result bit comes from a 4-to-1 multiplexer. The four code bits are the multiplexer's data inputs, and the two operand bits at that position are its selects.

The same code goes to every bit position at once, so a single code turns an N-bit operand pair into an N-bit result. A parameter chooses one of two output forms. The first is a registered stage: a valid strobe captures the result, and it appears one clock later with an output valid flag. The second is a purely combinational path in which the valid flag passes straight through.

Top module: `tt_logic_unit`

## Requirements
- R1: Result bit i equals code bit func[{op_a[i], op_b[i]}]. With op_a[i] as the high select and op_b[i] as the low select, the cases are: a=0,b=0 gives func[0]; a=0,b=1 gives func[1]; a=1,b=0 gives func[2]; a=1,b=1 gives func[3].
- R2: Code 4'b0000 gives an all-zero result and code 4'b1111 gives an all-ones result, whatever the operands are.
- R3: With codes written func[3:0], the named functions are AND=1000, OR=1110, XOR=0110, XNOR=1001, NAND=0111, NOR=0001, pass A=1100, invert A=0011, pass B=1010 and invert B=0101.
- R4: One code is applied to every bit position in the same cycle. Result bit i depends only on op_a[i], op_b[i] and the code.
- R5: When REG_OUT=1, in_valid high at a rising clock edge captures the operands and code. The matching result appears on `result`, with out_valid high, after that same edge, which is one clock later.
- R6: When REG_OUT=1, a clock edge with in_valid low drives out_valid low on the next cycle and leaves `result` unchanged, even if the operands or the code change.
- R7: When REG_OUT=1, a synchronous active-high reset sets out_valid to 0 and result to 0 at the next rising edge.
- R8: When REG_OUT=0, `result` follows the operands and code combinationally and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered stage |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_a | input | WIDTH | Operand A, drives the high select of each multiplexer |
| op_b | input | WIDTH | Operand B, drives the low select of each multiplexer |
| func | input | 4 | Truth-table function code |
| out_valid | output | 1 | Result is valid |
| result | output | WIDTH | Bitwise function result |

## Verification
The bench builds two copies of the block. One has WIDTH=16 and REG_OUT=1, which brings the capture latency, the hold-on-idle behaviour and the reset clearing within reach. The other has WIDTH=8 and REG_OUT=0, which exercises the combinational pass-through form in the same cycle as the stimulus. All sixteen codes are run over patterns chosen so that every (a,b) pair appears at many bit positions, and over random operands, so each truth-table entry is tested at every bit of the wide instance.

// File: rtl/tt_logic_pkg.sv
package tt_logic_pkg;

    typedef logic [3:0] func_code_t;

    // Truth-table codes, bit index = {a, b}
    localparam func_code_t FN_ZERO = 4'b0000;
    localparam func_code_t FN_AND  = 4'b1000;
    localparam func_code_t FN_OR   = 4'b1110;
    localparam func_code_t FN_XOR  = 4'b0110;
    localparam func_code_t FN_XNOR = 4'b1001;
    localparam func_code_t FN_NAND = 4'b0111;
    localparam func_code_t FN_NOR  = 4'b0001;
    localparam func_code_t FN_PA   = 4'b1100;
    localparam func_code_t FN_NA   = 4'b0011;
    localparam func_code_t FN_PB   = 4'b1010;
    localparam func_code_t FN_NB   = 4'b0101;
    localparam func_code_t FN_ONE  = 4'b1111;

endpackage

// File: rtl/tt_mux4.sv
module tt_mux4 (
    input  logic [3:0] data,
    input  logic       sel_hi,
    input  logic       sel_lo,
    output logic       y
);
    logic lo_pair;
    logic hi_pair;

    always_comb begin
        lo_pair = sel_lo ? data[1] : data[0];
        hi_pair = sel_lo ? data[3] : data[2];
        y       = sel_hi ? hi_pair : lo_pair;
    end
endmodule

// File: rtl/tt_bit_array.sv
module tt_bit_array #(
    parameter int WIDTH = 16
) (
    input  tt_logic_pkg::func_code_t func,
    input  logic [WIDTH-1:0]         op_a,
    input  logic [WIDTH-1:0]         op_b,
    output logic [WIDTH-1:0]         res
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        tt_mux4 i_mux (
            .data   (func),
            .sel_hi (op_a[i]),
            .sel_lo (op_b[i]),
            .y      (res[i])
        );
    end
endmodule

// File: rtl/tt_out_stage.sv
module tt_out_stage #(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] res_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] res_out
);
    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic             vld;
            logic [WIDTH-1:0] res;
        } stage_t;

        stage_t st_d;
        stage_t st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.res = res_in;
            end
            if (rst) begin
                st_d = '0;
            end
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign out_valid = st_q.vld;
        assign res_out   = st_q.res;
    end else begin : g_comb
        logic unused_clkrst;
        assign unused_clkrst = clk ^ rst;
        assign out_valid     = in_valid;
        assign res_out       = res_in;
    end
endmodule

// File: rtl/tt_logic_unit.sv
module tt_logic_unit #(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       func,
    output logic             out_valid,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] mux_res;

    tt_bit_array #(.WIDTH(WIDTH)) i_array (
        .func (func),
        .op_a (op_a),
        .op_b (op_b),
        .res  (mux_res)
    );

    tt_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) i_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .res_in    (mux_res),
        .out_valid (out_valid),
        .res_out   (result)
    );
endmodule

// File: rtl/tt_logic_unit_chk.sv
module tt_logic_unit_chk #(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       func,
    input logic             out_valid,
    input logic [WIDTH-1:0] result
);
    if (REG_OUT) begin : g_reg_chk
        AST_CAPTURE_VALID: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R5
        AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid); // R6
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(result)); // R6
        AST_BIT0_SELECT: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> result[0] == $past(func[{op_a[0], op_b[0]}])); // R1
        AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
            (in_valid && func == 4'b0000) |=> result == '0); // R2
        AST_ONE_CODE: assert property (@(posedge clk) disable iff (rst)
            (in_valid && func == 4'b1111) |=> result == '1); // R2
        AST_AND_CODE: assert property (@(posedge clk) disable iff (rst)
            (in_valid && func == 4'b1000) |=> result == $past(op_a & op_b)); // R3
        AST_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> (!out_valid && result == '0)); // R7
    end else begin : g_comb_chk
        always_comb begin
            AST_PASS_VALID: assert (out_valid == in_valid); // R8
        end
    end
endmodule

bind tt_logic_unit tt_logic_unit_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) i_chk (.*);

// File: tb/test_tt_logic_unit.sv
module test_tt_logic_unit;
    import tt_logic_pkg::*;

    localparam int W  = 16;
    localparam int CW = 8;

    typedef struct packed {
        logic [3:0]   f;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] e;
    } vec_t;

    localparam vec_t VECS [0:13] = '{
        '{FN_ZERO, 16'hF0F0, 16'hCCCC, 16'h0000},
        '{FN_AND,  16'hF0F0, 16'hCCCC, 16'hC0C0},
        '{FN_OR,   16'hF0F0, 16'hCCCC, 16'hFCFC},
        '{FN_XOR,  16'hF0F0, 16'hCCCC, 16'h3C3C},
        '{FN_XNOR, 16'hF0F0, 16'hCCCC, 16'hC3C3},
        '{FN_NAND, 16'hF0F0, 16'hCCCC, 16'h3F3F},
        '{FN_NOR,  16'hF0F0, 16'hCCCC, 16'h0303},
        '{FN_PA,   16'hF0F0, 16'hCCCC, 16'hF0F0},
        '{FN_NA,   16'hF0F0, 16'hCCCC, 16'h0F0F},
        '{FN_PB,   16'hF0F0, 16'hCCCC, 16'hCCCC},
        '{FN_NB,   16'hF0F0, 16'hCCCC, 16'h3333},
        '{FN_ONE,  16'hF0F0, 16'hCCCC, 16'hFFFF},
        '{FN_AND,  16'h1234, 16'h00FF, 16'h0034},
        '{FN_XOR,  16'hAAAA, 16'h5555, 16'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [3:0]    func = '0;
    logic          out_valid;
    logic [W-1:0]  result;
    logic          c_valid;
    logic [CW-1:0] c_result;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    tt_logic_unit #(.WIDTH(W), .REG_OUT(1'b1)) i_tt_logic_unit (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .op_a (op_a), .op_b (op_b), .func (func),
        .out_valid (out_valid), .result (result)
    );

    tt_logic_unit #(.WIDTH(CW), .REG_OUT(1'b0)) i_tt_logic_unit_comb (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .op_a (op_a[CW-1:0]), .op_b (op_b[CW-1:0]), .func (func),
        .out_valid (c_valid), .result (c_result)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] tt_ref(input logic [3:0] f, input logic [W-1:0] a,
                                            input logic [W-1:0] b);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = f[{a[i], b[i]}];
        return r;
    endfunction

    // Drive one operation, check combinational copy at once and registered copy a cycle later
    task automatic run_op(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] e, input string req);
        @(negedge clk);
        func = f; op_a = a; op_b = b; in_valid = 1'b1;
        #1;
        chk(c_result == e[CW-1:0], {req, " R8 comb result"}, W'(c_result), W'(e[CW-1:0]));
        chk(c_valid == 1'b1, "R8 comb valid", W'(c_valid), 16'd1);
        @(negedge clk);
        chk(result == e, {req, " R5 reg result"}, result, e);
        chk(out_valid == 1'b1, "R5 out_valid", W'(out_valid), 16'd1);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", '0, '0);
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        logic [W-1:0] pa [0:5];
        // R7: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R7 out_valid in reset", W'(out_valid), 16'd0);
        chk(result == '0, "R7 result in reset", result, 16'd0);
        rst = 1'b0;

        // Named-function vector table (R2, R3)
        for (int k = 0; k < 14; k++) begin
            run_op(VECS[k].f, VECS[k].a, VECS[k].b, VECS[k].e, "R3 R2 table");
        end

        // Every code over corner and random operand patterns (R1, R4)
        pa[0] = 16'h0000; pa[1] = 16'hFFFF; pa[2] = 16'hF0F0;
        pa[3] = 16'hAAAA; pa[4] = 16'h8001; pa[5] = 16'h3C5A;
        for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < 6; p++) begin
                logic [W-1:0] b;
                b = pa[(p + 2) % 6] ^ 16'hCCCC;
                run_op(4'(f), pa[p], b, tt_ref(4'(f), pa[p], b), "R1 R4 sweep");
            end
            for (int r = 0; r < 4; r++) begin
                logic [W-1:0] a;
                logic [W-1:0] b;
                a = W'($urandom);
                b = W'($urandom);
                run_op(4'(f), a, b, tt_ref(4'(f), a, b), "R1 R4 random");
            end
        end

        // R4: single bit set, code AND, only that bit may rise
        run_op(FN_AND, 16'h0100, 16'hFFFF, 16'h0100, "R4 single bit");

        // R6: idle cycle drops valid and holds result despite new inputs
        run_op(FN_XOR, 16'h00FF, 16'h0F0F, 16'h0FF0, "R6 preload");
        held = result;
        func = FN_ONE; op_a = 16'h1111; op_b = 16'h2222;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 out_valid idle", W'(out_valid), 16'd0);
        chk(result == held, "R6 result held", result, held);
        @(negedge clk);
        chk(result == held, "R6 result held 2", result, held);

        // R7: mid-run reset clears state
        run_op(FN_ONE, 16'h0, 16'h0, 16'hFFFF, "R2 before reset");
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 out_valid after reset", W'(out_valid), 16'd0);
        chk(result == '0, "R7 result after reset", result, 16'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 stays idle", W'(out_valid), 16'd0);

        finish_run();
    end
endmodule